// File: doc/BRIEF.md
# Scoreboard Issue, Dispatch and Write-Back Controller

This controller sequences instructions for three execution units: an adder, a multiplier and a divider. Each unit has a single staging slot in front of it. A single instruction register feeds the controller. Each cycle the controller decides three things. The first is whether the presented instruction moves into the staging slot of its unit. The second is which staged instructions have all their operands and may read the register file and start. The third is which finished result may be written back. Splitting issue from operand dispatch means that an instruction waiting for data blocks only its own unit. An independent instruction behind it still issues to another unit and runs.

The controller keeps a pending-producer bit for every architectural register. This bit blocks a second writer of the same register and holds dependent readers. It also keeps an issue-order age for every staged and executing instruction. Write-back uses these ages in a safe-to-write test. A result is held back while an older staged instruction has not yet read that register. A younger reader does not hold it back, because that reader is waiting for the result. The controller models unit latency with its own counters. It does not perform the arithmetic.

Each staging slot is a two-state machine. In SLOT_EMPTY it moves to SLOT_HELD when an instruction issues into it (transition *load*). In SLOT_HELD it returns to SLOT_EMPTY when the instruction dispatches (transition *dispatch*). Each execution unit is a three-state machine. It moves from EX_IDLE to EX_RUN on *start*. It stays in EX_RUN for the unit latency and then moves to EX_DONE (transition *finish*). It returns from EX_DONE to EX_IDLE when granted write-back (transition *retire*).

Top module: `sb_scoreboard`

## Requirements
- R1: Unit codes are 0 = adder, 1 = multiplier, 2 = divider, and code 3 is never accepted. ir_accept is high in the same cycle as ir_valid when two conditions hold: the staging slot of the named unit is empty at the start of the cycle, and no accepted instruction that has not yet written back targets ir_dst.
- R2: An instruction that is not accepted must stay on the ir_* inputs. Nothing behind it is accepted, even when the later instruction uses a different, free unit.
- R3: At most one in-flight instruction targets a given register. A second writer of a register is accepted no earlier than the cycle after the first writer's write-back.
- R4: A staged instruction dispatches when its unit is in EX_IDLE and neither source register has an in-flight producer. In the dispatch cycle, disp_fire[u] is high and disp_rd_a/disp_rd_b carry its two source register numbers in field u (bits u*REG_W upward). Dispatch happens no earlier than the cycle after issue.
- R5: An independent instruction behind a stalled dependent instruction dispatches and writes back before the dependent one.
- R6: A unit with latency LAT that dispatches in cycle d has its result eligible for write-back from cycle d+LAT+1.
- R7: A finished result is not written while an older staged instruction has a source equal to its destination. It is written in the cycle after that reader dispatches, when nothing else blocks it.
- R8: A staged instruction issued after the writer, reading the writer's destination, never delays that write.
- R9: At most one write-back happens per cycle. Among the eligible results, the one issued earliest is written first.
- R10: A staged reader waiting on a register dispatches in the cycle after that register's write-back, if its unit is idle.
- R11: After reset, disp_fire is 0 and wb_valid is 0, and no register has a pending producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_valid | input | 1 | Instruction register holds an instruction |
| ir_unit | input | 2 | Unit code of the instruction (0 add, 1 mul, 2 div) |
| ir_dst | input | REG_W | Destination register |
| ir_src_a | input | REG_W | First source register |
| ir_src_b | input | REG_W | Second source register |
| ir_accept | output | 1 | Instruction issues this cycle |
| disp_fire | output | 3 | Per-unit dispatch strobe |
| disp_rd_a | output | 3*REG_W | Per-unit first register-file read address |
| disp_rd_b | output | 3*REG_W | Per-unit second register-file read address |
| wb_valid | output | 1 | A result is written this cycle |
| wb_unit | output | 2 | Unit whose result is written |
| wb_dst | output | REG_W | Register written |

## Verification
The bench uses the default parameters: 16 registers, a 5-bit age, and latencies of 2, 4 and 6 cycles. A 6-cycle divider next to a 4-cycle multiplier lets both finish in the same cycle, which exercises the oldest-first choice. The random phase draws registers only from 0 to 7, so WAW stalls, RAW waits and WAR holds occur often. More than 32 issues in that phase wrap the 5-bit age counter, which tests the modular age compare.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        U_ADD  = 2'd0,
        U_MUL  = 2'd1,
        U_DIV  = 2'd2,
        U_NONE = 2'd3
    } unit_e;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_HELD
    } slot_state_e;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_RUN,
        EX_DONE
    } ex_state_e;
endpackage

// File: rtl/sb_stage_slot.sv
module sb_stage_slot
    import sb_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] ld_src_a,
    input  logic [REG_W-1:0] ld_src_b,
    input  logic             ld_rdy_a,
    input  logic             ld_rdy_b,
    input  logic [AGE_W-1:0] ld_age,
    input  logic             wb_valid,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             go,
    output logic             occupied,
    output logic             ready,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] src_a,
    output logic [REG_W-1:0] src_b,
    output logic [AGE_W-1:0] age
);
    slot_state_e state, state_nx;
    logic        rdy_a, rdy_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_EMPTY: if (load) state_nx = SLOT_HELD;
            SLOT_HELD:  if (go)   state_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst   <= '0;
            src_a <= '0;
            src_b <= '0;
            age   <= '0;
            rdy_a <= 1'b0;
            rdy_b <= 1'b0;
        end else if (load) begin
            dst   <= ld_dst;
            src_a <= ld_src_a;
            src_b <= ld_src_b;
            age   <= ld_age;
            rdy_a <= ld_rdy_a;
            rdy_b <= ld_rdy_b;
        end else if (state == SLOT_HELD && wb_valid) begin
            if (src_a == wb_dst) rdy_a <= 1'b1;
            if (src_b == wb_dst) rdy_b <= 1'b1;
        end
    end

    always_comb begin
        occupied = (state == SLOT_HELD);
        ready    = (state == SLOT_HELD) && rdy_a && rdy_b;
    end

    // R1
    load_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> state == SLOT_EMPTY);

    // R4
    go_needs_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (state == SLOT_HELD && rdy_a && rdy_b));

    // R4
    slot_frees_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> state == SLOT_EMPTY);
endmodule

// File: rtl/sb_exec_unit.sv
module sb_exec_unit
    import sb_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int AGE_W = 5,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] st_dst,
    input  logic [AGE_W-1:0] st_age,
    input  logic             grant,
    output logic             idle,
    output logic             done,
    output logic [REG_W-1:0] dst,
    output logic [AGE_W-1:0] age
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    ex_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   run_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            EX_IDLE: if (start)      state_nx = EX_RUN;
            EX_RUN:  if (cnt == '0)  state_nx = EX_DONE;
            EX_DONE: if (grant)      state_nx = EX_IDLE;
            default:                 state_nx = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            dst <= '0;
            age <= '0;
        end else if (start) begin
            cnt <= CNT_W'(LAT - 1);
            dst <= st_dst;
            age <= st_age;
        end else if (state == EX_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        idle = (state == EX_IDLE);
        done = (state == EX_DONE);
    end

    // checker counter: cycles spent in EX_RUN for the current operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_seen <= '0;
        else if (start)            run_seen <= '0;
        else if (state == EX_RUN)  run_seen <= run_seen + 1'b1;
    end

    // R4
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == EX_IDLE);

    // R6
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EX_DONE && $past(state) == EX_RUN) |-> run_seen == (CNT_W+1)'(LAT));

    // R7
    done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EX_DONE && !grant) |=> state == EX_DONE);

    // R9
    grant_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state == EX_DONE);
endmodule

// File: rtl/sb_wb_select.sv
module sb_wb_select #(
    parameter int REG_W = 4,
    parameter int AGE_W = 5,
    parameter int N     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     done,
    input  logic [REG_W-1:0] ex_dst   [N],
    input  logic [AGE_W-1:0] ex_age   [N],
    input  logic [N-1:0]     slot_occ,
    input  logic [REG_W-1:0] slot_src_a [N],
    input  logic [REG_W-1:0] slot_src_b [N],
    input  logic [AGE_W-1:0] slot_age [N],
    output logic [N-1:0]     grant
);
    logic [N-1:0] safe;

    function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    always_comb begin
        for (int u = 0; u < N; u++) begin
            safe[u] = done[u];
            for (int s = 0; s < N; s++) begin
                if (slot_occ[s] && is_older(slot_age[s], ex_age[u]) &&
                    (slot_src_a[s] == ex_dst[u] || slot_src_b[s] == ex_dst[u]))
                    safe[u] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int u = 0; u < N; u++) begin
            grant[u] = safe[u];
            for (int v = 0; v < N; v++) begin
                if (v != u && safe[v] && is_older(ex_age[v], ex_age[u]))
                    grant[u] = 1'b0;
            end
        end
    end

    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    write_when_any_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|safe) |-> (|grant));
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int AGE_W   = 5,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 4,
    parameter int LAT_DIV = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ir_valid,
    input  logic [1:0]                 ir_unit,
    input  logic [REG_W-1:0]           ir_dst,
    input  logic [REG_W-1:0]           ir_src_a,
    input  logic [REG_W-1:0]           ir_src_b,
    output logic                       ir_accept,
    output logic [NUM_UNITS-1:0]       disp_fire,
    output logic [NUM_UNITS*REG_W-1:0] disp_rd_a,
    output logic [NUM_UNITS*REG_W-1:0] disp_rd_b,
    output logic                       wb_valid,
    output logic [1:0]                 wb_unit,
    output logic [REG_W-1:0]           wb_dst
);
    localparam int NUM_REGS = 2 ** REG_W;

    logic [NUM_REGS-1:0]  prod_valid;
    logic [AGE_W-1:0]     age_ctr;

    logic [NUM_UNITS-1:0] slot_occ, slot_ready, load, go;
    logic [REG_W-1:0]     slot_dst   [NUM_UNITS];
    logic [REG_W-1:0]     slot_src_a [NUM_UNITS];
    logic [REG_W-1:0]     slot_src_b [NUM_UNITS];
    logic [AGE_W-1:0]     slot_age   [NUM_UNITS];

    logic [NUM_UNITS-1:0] ex_idle, ex_done, grant;
    logic [REG_W-1:0]     ex_dst [NUM_UNITS];
    logic [AGE_W-1:0]     ex_age [NUM_UNITS];

    logic slot_busy_sel, unit_known, rdy_a_now, rdy_b_now;

    // issue decision
    always_comb begin
        slot_busy_sel = 1'b0;
        unit_known    = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (ir_unit == 2'(u)) begin
                unit_known    = 1'b1;
                slot_busy_sel = slot_occ[u];
            end
        end
        ir_accept = ir_valid && unit_known && !slot_busy_sel && !prod_valid[ir_dst];
        for (int u = 0; u < NUM_UNITS; u++)
            load[u] = ir_accept && (ir_unit == 2'(u));
        rdy_a_now = !prod_valid[ir_src_a] || (wb_valid && wb_dst == ir_src_a);
        rdy_b_now = !prod_valid[ir_src_b] || (wb_valid && wb_dst == ir_src_b);
    end

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            localparam int LAT = (u == 0) ? LAT_ADD : (u == 1) ? LAT_MUL : LAT_DIV;

            sb_stage_slot #(.REG_W(REG_W), .AGE_W(AGE_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load[u]),
                .ld_dst   (ir_dst),
                .ld_src_a (ir_src_a),
                .ld_src_b (ir_src_b),
                .ld_rdy_a (rdy_a_now),
                .ld_rdy_b (rdy_b_now),
                .ld_age   (age_ctr),
                .wb_valid (wb_valid),
                .wb_dst   (wb_dst),
                .go       (go[u]),
                .occupied (slot_occ[u]),
                .ready    (slot_ready[u]),
                .dst      (slot_dst[u]),
                .src_a    (slot_src_a[u]),
                .src_b    (slot_src_b[u]),
                .age      (slot_age[u])
            );

            assign go[u] = slot_ready[u] && ex_idle[u];
            assign disp_rd_a[u*REG_W +: REG_W] = slot_src_a[u];
            assign disp_rd_b[u*REG_W +: REG_W] = slot_src_b[u];

            sb_exec_unit #(.REG_W(REG_W), .AGE_W(AGE_W), .LAT(LAT)) u_exec (
                .clk    (clk),
                .rst_n  (rst_n),
                .start  (go[u]),
                .st_dst (slot_dst[u]),
                .st_age (slot_age[u]),
                .grant  (grant[u]),
                .idle   (ex_idle[u]),
                .done   (ex_done[u]),
                .dst    (ex_dst[u]),
                .age    (ex_age[u])
            );
        end
    endgenerate

    assign disp_fire = go;

    sb_wb_select #(.REG_W(REG_W), .AGE_W(AGE_W), .N(NUM_UNITS)) u_wbsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (ex_done),
        .ex_dst     (ex_dst),
        .ex_age     (ex_age),
        .slot_occ   (slot_occ),
        .slot_src_a (slot_src_a),
        .slot_src_b (slot_src_b),
        .slot_age   (slot_age),
        .grant      (grant)
    );

    always_comb begin
        wb_valid = |grant;
        wb_unit  = 2'd0;
        wb_dst   = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (grant[u]) begin
                wb_unit = 2'(u);
                wb_dst  = ex_dst[u];
            end
        end
    end

    // producer table and issue-order age
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_valid <= '0;
            age_ctr    <= '0;
        end else begin
            if (wb_valid)  prod_valid[wb_dst] <= 1'b0;
            if (ir_accept) begin
                prod_valid[ir_dst] <= 1'b1;
                age_ctr            <= age_ctr + 1'b1;
            end
        end
    end

    // R3
    wb_has_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> prod_valid[wb_dst]);

    // R3
    producer_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_accept |=> prod_valid[$past(ir_dst)]);

    // R1
    unknown_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_unit == 2'd3) |-> !ir_accept);
endmodule

// File: tb/sb_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_scoreboard_tb;
    localparam int REG_W = 4;
    localparam int NU    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_valid = 1'b0;
    logic [1:0] ir_unit = '0;
    logic [REG_W-1:0] ir_dst = '0, ir_src_a = '0, ir_src_b = '0;
    logic ir_accept;
    logic [NU-1:0] disp_fire;
    logic [NU*REG_W-1:0] disp_rd_a, disp_rd_b;
    logic wb_valid;
    logic [1:0] wb_unit;
    logic [REG_W-1:0] wb_dst;

    always #2.5 clk = ~clk;

    sb_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n), .ir_valid(ir_valid), .ir_unit(ir_unit),
        .ir_dst(ir_dst), .ir_src_a(ir_src_a), .ir_src_b(ir_src_b),
        .ir_accept(ir_accept), .disp_fire(disp_fire), .disp_rd_a(disp_rd_a),
        .disp_rd_b(disp_rd_b), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst)
    );

    typedef struct { int unit; int dst; int sa; int sb; } ins_t;
    ins_t q[$];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int lat [NU] = '{2, 4, 6};
    // reference model state
    int m_occ[NU], m_dst[NU], m_sa[NU], m_sb[NU], m_ra[NU], m_rb[NU], m_age[NU];
    int m_ex[NU], m_cnt[NU], m_xdst[NU], m_xage[NU];
    int m_prod[16];
    int m_agec = 0;
    // observed event cycles
    int acc_cyc[NU], disp_cyc[NU], wb_cyc[NU];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int u, input int d, input int a, input int b);
        ins_t x;
        x.unit = u; x.dst = d; x.sa = a; x.sb = b;
        q.push_back(x);
    endtask

    function automatic bit model_empty();
        for (int u = 0; u < NU; u++)
            if (m_occ[u] != 0 || m_ex[u] != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic step();
        int acc, g, wbd, iu, id, ia, ib;
        int go [NU];
        int safe [NU];
        @(negedge clk);
        if (q.size() > 0) begin
            ir_valid = 1'b1;
            ir_unit  = 2'(q[0].unit);
            ir_dst   = REG_W'(q[0].dst);
            ir_src_a = REG_W'(q[0].sa);
            ir_src_b = REG_W'(q[0].sb);
            iu = q[0].unit; id = q[0].dst; ia = q[0].sa; ib = q[0].sb;
        end else begin
            ir_valid = 1'b0;
            iu = 3; id = 0; ia = 0; ib = 0;
        end
        #1;
        acc = (q.size() > 0 && iu < 3) ? ((m_occ[iu] == 0 && m_prod[id] == 0) ? 1 : 0) : 0;
        for (int u = 0; u < NU; u++) begin
            go[u] = (m_occ[u] != 0 && m_ra[u] != 0 && m_rb[u] != 0 && m_ex[u] == 0) ? 1 : 0;
            safe[u] = (m_ex[u] == 2) ? 1 : 0;
            for (int s = 0; s < NU; s++)
                if (m_occ[s] != 0 && m_age[s] < m_xage[u] &&
                    (m_sa[s] == m_xdst[u] || m_sb[s] == m_xdst[u])) safe[u] = 0;
        end
        g = -1;
        for (int u = 0; u < NU; u++)
            if (safe[u] != 0 && (g < 0 || m_xage[u] < m_xage[g])) g = u;
        wbd = (g >= 0) ? m_xdst[g] : 0;

        // R1 R2: issue decision every cycle
        chk(int'(ir_accept) == acc, "R1", "ir_accept", int'(ir_accept), acc);
        // R4: dispatch strobes and read addresses
        for (int u = 0; u < NU; u++) begin
            chk(int'(disp_fire[u]) == go[u], "R4", "disp_fire", int'(disp_fire[u]), go[u]);
            if (go[u] != 0) begin
                chk(int'(disp_rd_a[u*REG_W +: REG_W]) == m_sa[u], "R4", "disp_rd_a",
                    int'(disp_rd_a[u*REG_W +: REG_W]), m_sa[u]);
                chk(int'(disp_rd_b[u*REG_W +: REG_W]) == m_sb[u], "R4", "disp_rd_b",
                    int'(disp_rd_b[u*REG_W +: REG_W]), m_sb[u]);
            end
        end
        // R7 R9: write-back choice
        chk(int'(wb_valid) == ((g >= 0) ? 1 : 0), "R9", "wb_valid", int'(wb_valid), (g >= 0) ? 1 : 0);
        if (g >= 0 && wb_valid) begin
            chk(int'(wb_unit) == g, "R9", "wb_unit", int'(wb_unit), g);
            chk(int'(wb_dst) == wbd, "R7", "wb_dst", int'(wb_dst), wbd);
        end

        // record observed events
        if (ir_accept && iu < 3) acc_cyc[iu] = cyc;
        for (int u = 0; u < NU; u++) if (disp_fire[u]) disp_cyc[u] = cyc;
        if (wb_valid) wb_cyc[wb_unit] = cyc;

        // advance the model
        for (int u = 0; u < NU; u++) begin
            if (g == u) m_ex[u] = 0;
            else if (m_ex[u] == 1) begin
                if (m_cnt[u] == 0) m_ex[u] = 2;
                else m_cnt[u]--;
            end
            if (go[u] != 0) begin
                m_ex[u] = 1; m_cnt[u] = lat[u] - 1;
                m_xdst[u] = m_dst[u]; m_xage[u] = m_age[u];
                m_occ[u] = 0;
            end else if (m_occ[u] != 0 && g >= 0) begin
                if (m_sa[u] == wbd) m_ra[u] = 1;
                if (m_sb[u] == wbd) m_rb[u] = 1;
            end
        end
        if (acc != 0) begin
            m_occ[iu] = 1; m_dst[iu] = id; m_sa[iu] = ia; m_sb[iu] = ib;
            m_ra[iu] = (m_prod[ia] == 0 || (g >= 0 && wbd == ia)) ? 1 : 0;
            m_rb[iu] = (m_prod[ib] == 0 || (g >= 0 && wbd == ib)) ? 1 : 0;
            m_age[iu] = m_agec; m_agec++;
        end
        if (g >= 0) m_prod[wbd] = 0;
        if (acc != 0) begin
            m_prod[id] = 1;
            void'(q.pop_front());
        end
        cyc++;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            step();
            if (q.size() == 0 && model_empty()) break;
        end
        step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int u = 0; u < NU; u++) begin
            m_occ[u] = 0; m_ex[u] = 0; m_cnt[u] = 0; m_xdst[u] = 0; m_xage[u] = 0;
            m_dst[u] = 0; m_sa[u] = 0; m_sb[u] = 0; m_ra[u] = 0; m_rb[u] = 0; m_age[u] = 0;
            acc_cyc[u] = 0; disp_cyc[u] = 0; wb_cyc[u] = 0;
        end
        for (int r = 0; r < 16; r++) m_prod[r] = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle outputs after reset
        chk(disp_fire == '0, "R11", "disp_fire", int'(disp_fire), 0);
        chk(wb_valid == 1'b0, "R11", "wb_valid", int'(wb_valid), 0);

        // R11: every register free: all-different writers issue back to back
        push(0, 1, 2, 3); push(1, 4, 5, 6); push(2, 7, 8, 9);
        drain();
        chk(acc_cyc[1] == acc_cyc[0] + 1, "R11", "second accept", acc_cyc[1], acc_cyc[0] + 1);

        // R5 R6 R9 R10: divide, dependent add, independent multiply
        push(2, 0, 2, 4); push(0, 10, 0, 8); push(1, 12, 8, 14);
        drain();
        chk(disp_cyc[1] < disp_cyc[0], "R5", "mul dispatch before add", disp_cyc[1], disp_cyc[0]);
        chk(wb_cyc[1] < wb_cyc[0], "R5", "mul write before add", wb_cyc[1], wb_cyc[0]);
        chk(wb_cyc[2] == disp_cyc[2] + 7, "R6", "div result cycle", wb_cyc[2], disp_cyc[2] + 7);
        chk(wb_cyc[1] == wb_cyc[2] + 1, "R9", "older div written first", wb_cyc[1], wb_cyc[2] + 1);
        chk(disp_cyc[0] == wb_cyc[2] + 1, "R10", "add wakes after F0", disp_cyc[0], wb_cyc[2] + 1);

        // R7: add writing F8 must wait for the older multiply to read F8
        push(2, 0, 2, 4); push(1, 6, 0, 8); push(0, 8, 10, 12);
        drain();
        chk(wb_cyc[0] == disp_cyc[1] + 1, "R7", "add write after mul read", wb_cyc[0], disp_cyc[1] + 1);
        chk(wb_cyc[0] > disp_cyc[0] + 3, "R7", "add write held", wb_cyc[0], disp_cyc[0] + 3);

        // R8 R10: younger reader of F3 does not hold the add
        push(0, 3, 1, 2); push(1, 5, 3, 4);
        drain();
        chk(wb_cyc[0] == disp_cyc[0] + 3, "R8", "add write not delayed", wb_cyc[0], disp_cyc[0] + 3);
        chk(disp_cyc[1] == wb_cyc[0] + 1, "R10", "mul wakes after F3", disp_cyc[1], wb_cyc[0] + 1);

        // R3 R2: second writer of F7 waits; independent multiply behind it waits too
        push(2, 7, 1, 2); push(0, 7, 3, 4); push(1, 9, 5, 6);
        drain();
        chk(acc_cyc[0] == wb_cyc[2] + 1, "R3", "second writer accept", acc_cyc[0], wb_cyc[2] + 1);
        chk(acc_cyc[1] == acc_cyc[0] + 1, "R2", "blocked follower accept", acc_cyc[1], acc_cyc[0] + 1);

        // random stream over registers 0..7, compared every cycle
        for (int i = 0; i < 400; i++)
            push(int'($urandom_range(0, 2)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
        drain();
        chk(q.size() == 0, "R1", "random stream drained", q.size(), 0);

        finish_run();
    end
endmodule